// File: doc/BRIEF.md
# Path-Correlated Branch Direction Predictor

This block guesses whether a conditional branch will be taken, using both the branch's own address and the outcomes of the branches resolved just before it. A shift register holds the last few resolved directions. That history value picks one of several banks of saturating counters. Word-address bits of the branch pick the counter inside the bank. Because the history takes part in the choice, one branch can hold different counters for different paths leading up to it.

Fetch presents a lookup request and receives the guess combinationally in the same cycle. Execute later presents a resolved branch on the update channel. The update moves one counter and then shifts the outcome into the history. Updates are never back-pressured: `upd_ready` is always high, so every cycle with `upd_valid` high is one accepted update. The lookup channel has no ready: the answer is qualified by `pred_valid`, which follows `lk_valid` in the same cycle. Counters carry no tag, and branches that share index bits share counters.

Top module: `corr_bpred`

## Requirements
- R1: After reset every counter holds the weakly-not-taken value (MSB clear, all lower bits set; binary 01 for 2-bit counters), and the history is all zeros.
- R2: A lookup answers in the same cycle from the counter at {history, lk_pc}: `pred_ctr` is that counter and `pred_taken` is its MSB.
- R3: An accepted update with `upd_taken` high adds one to its counter, and a counter at all ones stays at all ones.
- R4: An accepted update with `upd_taken` low subtracts one from its counter, and a counter at zero stays at zero.
- R5: After an accepted update the history shifts left by one, the outcome enters bit 0 (1 = taken) and the oldest bit is dropped; the new history picks the bank for later lookups and updates.
- R6: An update changes the counter in the bank picked by the history as it stood before that update.
- R7: No tag is kept: branches whose word-address bits k+1..2 match read and write the same counter, whatever their other address bits.
- R8: When a lookup and an update hit the same counter in one cycle, the lookup returns the value from before the update.
- R9: With `lk_valid` low, `pred_valid`, `pred_taken` and `pred_ctr` are all zero.
- R10: With `upd_valid` low, no counter and no history bit changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request present |
| lk_pc | input | IDX_W | Word-address bits k+1..2 of the fetch PC |
| pred_valid | output | 1 | Prediction present, same cycle as lk_valid |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_ctr | output | CTR_W | Counter value behind the prediction |
| upd_valid | input | 1 | Resolved branch present |
| upd_ready | output | 1 | Always high; updates are never stalled |
| upd_pc | input | IDX_W | Word-address bits k+1..2 of the resolved branch PC |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
The lookup and the update can land in one cycle, both on the same counter and on different ones, and a lookup can also fall on a bank that the same cycle's history shift is about to leave. The bench provokes this by driving both channels together on shared and on distinct indices, within scripted saturation runs and in a long random mix. A reference model in the bench forms each expected answer from its counters and history before it applies that cycle's update, so a design that forwards the new value or shifts the history first is caught at the lookup outputs.

// File: rtl/corr_bpred_pkg.sv
package corr_bpred_pkg;

  typedef enum logic {
    DIR_NOT_TAKEN = 1'b0,
    DIR_TAKEN     = 1'b1
  } dir_e;

  // weakly-not-taken: top bit clear, every lower bit set
  function automatic int unsigned weak_nt(input int unsigned width);
    return (32'd1 << (width - 1)) - 32'd1;
  endfunction

endpackage

// File: rtl/cbp_hist.sv
module cbp_hist #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_nxt;

  generate
    if (HIST_W == 1) begin : g_one
      assign hist_nxt = bit_in;
    end else begin : g_many
      assign hist_nxt = {hist_q[HIST_W-2:0], bit_in};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (shift_en) begin
      hist_q <= hist_nxt;
    end
  end

  assign hist = hist_q;

endmodule

// File: rtl/cbp_sat_step.sv
module cbp_sat_step
  import corr_bpred_pkg::*;
#(
  parameter int CTR_W = 2
) (
  input  logic [CTR_W-1:0] cur,
  input  dir_e             dir,
  output logic [CTR_W-1:0] nxt
);

  localparam logic [CTR_W-1:0] TOP = '1;
  localparam logic [CTR_W-1:0] BOT = '0;
  localparam logic [CTR_W-1:0] ONE = CTR_W'(1);

  always_comb begin
    nxt = cur;
    if (dir == DIR_TAKEN) begin
      if (cur != TOP) nxt = cur + ONE;
    end else begin
      if (cur != BOT) nxt = cur - ONE;
    end
  end

endmodule

// File: rtl/cbp_bank.sv
module cbp_bank #(
  parameter int               IDX_W = 4,
  parameter int               CTR_W = 2,
  parameter logic [CTR_W-1:0] INIT  = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_idx,
  output logic [CTR_W-1:0] lk_ctr,
  input  logic [IDX_W-1:0] up_idx,
  output logic [CTR_W-1:0] up_ctr,
  input  logic             wr_en,
  input  logic [CTR_W-1:0] wr_ctr
);

  localparam int DEPTH = 1 << IDX_W;

  logic [CTR_W-1:0] ctr_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= INIT;
    end else if (wr_en) begin
      ctr_q[up_idx] <= wr_ctr;
    end
  end

  // both read ports see the stored value: a write lands after the edge
  assign lk_ctr = ctr_q[lk_idx];
  assign up_ctr = ctr_q[up_idx];

endmodule

// File: rtl/corr_bpred.sv
module corr_bpred
  import corr_bpred_pkg::*;
#(
  parameter int HIST_W = 2,
  parameter int CTR_W  = 2,
  parameter int IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [IDX_W+1:2] lk_pc,
  output logic             pred_valid,
  output logic             pred_taken,
  output logic [CTR_W-1:0] pred_ctr,
  input  logic             upd_valid,
  output logic             upd_ready,
  input  logic [IDX_W+1:2] upd_pc,
  input  logic             upd_taken
);

  localparam int               NBANK    = 1 << HIST_W;
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(weak_nt(CTR_W));

  logic [HIST_W-1:0] ghr_q;
  logic [IDX_W-1:0]  lk_idx;
  logic [IDX_W-1:0]  up_idx;
  logic [CTR_W-1:0]  bank_lk [NBANK];
  logic [CTR_W-1:0]  bank_up [NBANK];
  logic [CTR_W-1:0]  sel_lk;
  logic [CTR_W-1:0]  upd_old;
  logic [CTR_W-1:0]  upd_new;
  dir_e              upd_dir;

  assign lk_idx  = lk_pc;
  assign up_idx  = upd_pc;
  assign upd_dir = upd_taken ? DIR_TAKEN : DIR_NOT_TAKEN;

  cbp_hist #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (upd_valid),
    .bit_in   (upd_taken),
    .hist     (ghr_q)
  );

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic bank_wr;
      assign bank_wr = upd_valid && (ghr_q == HIST_W'(b));
      cbp_bank #(
        .IDX_W (IDX_W),
        .CTR_W (CTR_W),
        .INIT  (CTR_INIT)
      ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .lk_idx (lk_idx),
        .lk_ctr (bank_lk[b]),
        .up_idx (up_idx),
        .up_ctr (bank_up[b]),
        .wr_en  (bank_wr),
        .wr_ctr (upd_new)
      );
    end
  endgenerate

  assign sel_lk  = bank_lk[ghr_q];
  assign upd_old = bank_up[ghr_q];

  cbp_sat_step #(.CTR_W(CTR_W)) u_step (
    .cur (upd_old),
    .dir (upd_dir),
    .nxt (upd_new)
  );

  assign pred_valid = lk_valid;
  assign pred_ctr   = lk_valid ? sel_lk : '0;
  assign pred_taken = lk_valid & sel_lk[CTR_W-1];
  assign upd_ready  = 1'b1;

endmodule

// File: rtl/corr_bpred_chk.sv
module corr_bpred_chk #(
  parameter int HIST_W = 2,
  parameter int CTR_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic              pred_valid,
  input logic              pred_taken,
  input logic              upd_valid,
  input logic              upd_taken,
  input logic [HIST_W-1:0] ghr_q,
  input logic [CTR_W-1:0]  upd_old,
  input logic [CTR_W-1:0]  upd_new
);

  localparam logic [CTR_W-1:0] TOP = '1;
  localparam logic [CTR_W-1:0] ONE = CTR_W'(1);

  AST_HIST_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ghr_q == '0); // R1

  AST_SAT_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    upd_valid && upd_taken && upd_old == TOP |-> upd_new == TOP); // R3

  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    upd_valid && upd_taken && upd_old != TOP |-> upd_new == upd_old + ONE); // R3

  AST_SAT_AT_BOT: assert property (@(posedge clk) disable iff (rst)
    upd_valid && !upd_taken && upd_old == '0 |-> upd_new == '0); // R4

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    upd_valid && !upd_taken && upd_old != '0 |-> upd_new == upd_old - ONE); // R4

  AST_HIST_NEW_BIT: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> ghr_q[0] == $past(upd_taken)); // R5

  generate
    if (HIST_W > 1) begin : g_shift
      AST_HIST_SHIFTED: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> ghr_q[HIST_W-1:1] == $past(ghr_q[HIST_W-2:0])); // R5
    end
  endgenerate

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> !pred_valid && !pred_taken); // R9

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(ghr_q)); // R10

endmodule

bind corr_bpred corr_bpred_chk #(
  .HIST_W (HIST_W),
  .CTR_W  (CTR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lk_valid   (lk_valid),
  .pred_valid (pred_valid),
  .pred_taken (pred_taken),
  .upd_valid  (upd_valid),
  .upd_taken  (upd_taken),
  .ghr_q      (ghr_q),
  .upd_old    (upd_old),
  .upd_new    (upd_new)
);

// File: tb/sim_corr_bpred.sv
`timescale 1ns/1ps
module sim_corr_bpred;

  localparam int HIST_W = 2;
  localparam int CTR_W  = 2;
  localparam int IDX_W  = 4;
  localparam int NENT   = 1 << (HIST_W + IDX_W);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             lk_valid = 1'b0;
  logic [IDX_W+1:2] lk_pc = '0;
  logic             pred_valid;
  logic             pred_taken;
  logic [CTR_W-1:0] pred_ctr;
  logic             upd_valid = 1'b0;
  logic             upd_ready;
  logic [IDX_W+1:2] upd_pc = '0;
  logic             upd_taken = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  corr_bpred #(.HIST_W(HIST_W), .CTR_W(CTR_W), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_ctr(pred_ctr),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_pc(upd_pc),
    .upd_taken(upd_taken)
  );

  // reference model
  logic [CTR_W-1:0]  mdl_ctr [NENT];
  logic [HIST_W-1:0] mdl_ghr;

  // scoreboard: {pred_valid, pred_taken, pred_ctr}
  logic [CTR_W+1:0] exp_q [$];
  string            tag_q [$];

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic mdl_reset();
    for (int i = 0; i < NENT; i++) mdl_ctr[i] = 2'b01;
    mdl_ghr = '0;
  endtask

  // called at a falling edge; drives one cycle and queues the expected answer
  task automatic drive(input bit lv, input logic [31:0] lpc, input bit uv,
                       input logic [31:0] upc, input bit ut, input string tag);
    logic [CTR_W-1:0] c;
    int li;
    int ui;
    lk_valid  = lv;
    lk_pc     = lpc[IDX_W+1:2];
    upd_valid = uv;
    upd_pc    = upc[IDX_W+1:2];
    upd_taken = ut;
    li = int'({mdl_ghr, lpc[IDX_W+1:2]});
    c  = mdl_ctr[li];
    if (lv) exp_q.push_back({1'b1, c[CTR_W-1], c});
    else    exp_q.push_back('0);
    tag_q.push_back(tag);
    if (uv) begin
      ui = int'({mdl_ghr, upc[IDX_W+1:2]});
      if (ut && mdl_ctr[ui] != 2'b11) mdl_ctr[ui] = mdl_ctr[ui] + 2'b01;
      else if (!ut && mdl_ctr[ui] != 2'b00) mdl_ctr[ui] = mdl_ctr[ui] - 2'b01;
      mdl_ghr = {mdl_ghr[HIST_W-2:0], ut};
    end
    @(negedge clk);
  endtask

  task automatic look(input logic [31:0] pc, input string tag);
    drive(1'b1, pc, 1'b0, 32'h0, 1'b0, tag);
  endtask

  task automatic upd(input logic [31:0] pc, input bit t, input string tag);
    drive(1'b0, 32'h0, 1'b1, pc, t, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (exp_q.size() > 0) begin
        logic [CTR_W+1:0] e;
        logic [CTR_W+1:0] a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {pred_valid, pred_taken, pred_ctr};
        n_chk++;
        if (a !== e) begin
          n_fail++;
          $display("FAIL %s: got valid/taken/ctr=%b expected %b", t, a, e);
        end
      end
    end
  end

  localparam logic [31:0] PA = 32'h0000_1010; // index 4
  localparam logic [31:0] PB = 32'h0000_2024; // index 9
  localparam logic [31:0] PC = 32'h0000_0038; // index 14

  initial begin
    mdl_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state, several entries, history zero
    look(PA, "R1");
    look(PB, "R1");
    look(32'h0000_003C, "R1");
    look(32'h0000_0000, "R1");

    // R9: no lookup -> outputs quiet
    drive(1'b0, PA, 1'b0, 32'h0, 1'b0, "R9");
    drive(1'b0, PB, 1'b0, 32'h0, 1'b0, "R9");

    // R10: update inputs toggling but not valid
    drive(1'b0, 32'h0, 1'b0, PA, 1'b1, "R10");
    drive(1'b0, 32'h0, 1'b0, PA, 1'b1, "R10");
    look(PA, "R10 counter unchanged");
    upd(PB, 1'b0, "R10");              // history stays 00 if earlier shifts were ignored
    look(PA, "R10 history unchanged");

    // R6/R5: taken update in bank 00, then bank 01 is still weak
    upd(PA, 1'b1, "R6");                // bank00[A] -> 10, hist 01
    look(PA, "R5 bank01 untouched");
    upd(PB, 1'b0, "R5");                // hist 10
    upd(PB, 1'b0, "R5");                // hist 00
    look(PA, "R6 bank00 now taken");
    look(PC, "R2 neighbour index weak");

    // R3: saturate high with history held at 11
    for (int i = 0; i < 6; i++) upd(PA, 1'b1, "R3");
    look(PA, "R3 saturated high");
    upd(PA, 1'b1, "R3");
    look(PA, "R3 no wrap");
    upd(PA, 1'b0, "R3");                // hist 10, bank11 used for update
    upd(PB, 1'b1, "R3");                // hist 01
    upd(PB, 1'b1, "R3");                // hist 11
    look(PA, "R2 strong-1 still taken");

    // R4: saturate low with history held at 00
    for (int i = 0; i < 6; i++) upd(PC, 1'b0, "R4");
    look(PC, "R4 saturated low");
    upd(PC, 1'b0, "R4");
    look(PC, "R4 no wrap");

    // R7: aliasing over bits outside k+1..2
    upd(PA, 1'b1, "R7");
    upd(32'hABCD_0013, 1'b1, "R7");     // same index as PA
    look(32'h7777_0011, "R7 alias read");
    look(PA, "R7 alias read");

    // R8: same-cycle lookup and update on one entry
    drive(1'b1, PB, 1'b1, PB, 1'b1, "R8 old value");
    drive(1'b1, PB, 1'b1, PB, 1'b1, "R8 old value");
    drive(1'b1, PB, 1'b1, PB, 1'b0, "R8 old value");
    drive(1'b1, PA, 1'b1, PB, 1'b0, "R8 distinct entries");

    // random mix: R2, R5, R8
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      logic [31:0] b;
      a = $urandom();
      b = $urandom() & 32'h0000_001C;
      drive($urandom_range(0, 3) != 0, a, $urandom_range(0, 1) == 1,
            ($urandom_range(0, 1) == 1) ? a : b, $urandom_range(0, 1) == 1,
            "R2 R5 random mix");
    end

    drive(1'b0, 32'h0, 1'b0, 32'h0, 1'b0, "R9");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule